// File: doc/BRIEF.md
# Serial Status-Write and Block-Protect Unit

This unit is the slave side of a serial command port for a small non-volatile memory. It recognises one command, the status write, and keeps the two-bit block-protect level that the command sets. The serial lines (clock, active-low select and data in) are sampled on a fast local clock. A rising serial-clock edge while select is low shifts in one data bit, most significant bit first. A frame starts with an 8-bit command code. An 8-bit status byte follows it. Only two bits of that byte are kept.

The new protect level is committed when select rises, and only if exactly sixteen bits were clocked and the first eight matched the command code. A shorter frame, a longer frame and a wrong code all leave the level unchanged. A combinational check tells the array write logic whether a given word address is locked. This depends on the current level and on the array size selected: 512 words in extended mode or 256 words in base mode. The serial data output is never driven.

Top module: `bp_status_port`

## Requirements
- R1: After reset the protect level `bp_level` is 2'b00.
- R2: A frame of command code 8'h01 followed by a status byte S, both most significant bit first, sets `bp_level` to {S[3], S[2]} once `cs_n` rises after exactly 16 clocked bits.
- R3: A frame with fewer than 16 clocked bits leaves `bp_level` unchanged.
- R4: A frame with 17 or more clocked bits leaves `bp_level` unchanged.
- R5: A frame whose first eight bits are not 8'h01 leaves `bp_level` unchanged.
- R6: Status bits 7..4 and 1..0 have no effect on `bp_level`.
- R7: `bp_level` changes only just after `cs_n` rises, and holds steady while the port is selected.
- R8: With array size N (512 when `ext_mode`=1, 256 when 0), `addr_locked` is 1 for an address A < N under these rules: level 00 locks nothing; level 01 locks A >= 3N/4; level 10 locks A >= N/2; level 11 locks every A.
- R9: An address at or above the array size of the selected mode is never flagged as locked.
- R10: `sdo_oe` stays 0 at all times, so the data output is left at high impedance.
- R11: The bit count restarts whenever `cs_n` is high, so a valid frame that follows an aborted one is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low port select framing a command |
| si | input | 1 | Serial data in, most significant bit first |
| ext_mode | input | 1 | 1 selects the 512-word array, 0 the 256-word array |
| chk_addr | input | 9 | Word address to test for write protection |
| sdo | output | 1 | Serial data out value (never enabled) |
| sdo_oe | output | 1 | Output enable for sdo, held at 0 |
| bp_level | output | 2 | Current block-protect level |
| addr_locked | output | 1 | 1 when chk_addr is write-protected |

## Verification
The assertions assume that `sck`, `cs_n` and `si` stay stable for at least two local clock cycles between changes. This lets every serial edge be seen once by the input registers. The bench keeps each serial half-period at four local cycles and changes `si` only while `sck` is low. It holds `cs_n` steady around serial edges. Random frames vary the length from 14 to 18 bits, the command code and the status byte. Directed cases cover the boundaries at 15, 16 and 17 bits and every level in both array modes.

// File: rtl/bp_status_pkg.sv
package bp_status_pkg;
  localparam int unsigned CODE_BITS   = 8;
  localparam int unsigned DATA_BITS   = 8;
  localparam int unsigned FRAME_BITS  = CODE_BITS + DATA_BITS;
  localparam logic [CODE_BITS-1:0] STATUS_WR_CODE = 8'h01;
  localparam int unsigned LVL_LO_POS  = 2;
  localparam int unsigned LVL_HI_POS  = 3;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/bp_serial_sampler.sv
module bp_serial_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic bit_stb,
  output logic bit_val,
  output logic sel_n,
  output logic deselect_stb
);
  logic sck_q, sck_d, cs_q, cs_d, si_q;
  logic sck_q_n, sck_d_n, cs_q_n, cs_d_n, si_q_n;

  always_comb begin
    sck_q_n = sck;
    sck_d_n = sck_q;
    cs_q_n  = cs_n;
    cs_d_n  = cs_q;
    si_q_n  = si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      cs_q  <= 1'b1;
      cs_d  <= 1'b1;
      si_q  <= 1'b0;
    end else begin
      sck_q <= sck_q_n;
      sck_d <= sck_d_n;
      cs_q  <= cs_q_n;
      cs_d  <= cs_d_n;
      si_q  <= si_q_n;
    end
  end

  assign bit_stb      = sck_q & ~sck_d & ~cs_q;
  assign bit_val      = si_q;
  assign sel_n        = cs_q;
  assign deselect_stb = cs_q & ~cs_d;
endmodule

// File: rtl/bp_frame_rx.sv
module bp_frame_rx
  import bp_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic       sel_n,
  input  logic       deselect_stb,
  output logic       commit_stb,
  output logic [1:0] commit_lvl,
  output logic [$clog2(FRAME_BITS+2)-1:0] bit_cnt
);
  localparam int unsigned CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int unsigned CNT_SAT = FRAME_BITS + 1;

  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [DATA_BITS-1:0] shf_q, shf_n;
  logic                 code_ok_q, code_ok_n;
  logic                 cnt_en;

  assign cnt_en = bit_stb && (cnt_q != CNT_W'(CNT_SAT));

  always_comb begin
    cnt_n     = cnt_q;
    shf_n     = shf_q;
    code_ok_n = code_ok_q;
    if (sel_n) begin
      cnt_n     = '0;
      code_ok_n = 1'b0;
    end else begin
      if (cnt_en)  cnt_n = cnt_q + 1'b1;
      if (bit_stb) shf_n = {shf_q[DATA_BITS-2:0], bit_val};
      if (cnt_q == CNT_W'(CODE_BITS)) code_ok_n = (shf_q == STATUS_WR_CODE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      shf_q     <= '0;
      code_ok_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      shf_q     <= shf_n;
      code_ok_q <= code_ok_n;
    end
  end

  assign commit_stb = deselect_stb && code_ok_q && (cnt_q == CNT_W'(FRAME_BITS));
  assign commit_lvl = {shf_q[LVL_HI_POS], shf_q[LVL_LO_POS]};
  assign bit_cnt    = cnt_q;
endmodule

// File: rtl/bp_range_check.sv
module bp_range_check
  import bp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [1:0]        lvl,
  input  logic              ext_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int unsigned EXT_WORDS  = 1 << ADDR_W;
  localparam int unsigned BASE_WORDS = 1 << (ADDR_W - 1);

  logic [ADDR_W:0] size, lim_q, lim_h;
  logic            in_array;

  always_comb begin
    size     = ext_mode ? (ADDR_W+1)'(EXT_WORDS) : (ADDR_W+1)'(BASE_WORDS);
    lim_h    = size >> 1;
    lim_q    = size - (size >> 2);
    in_array = {1'b0, addr} < size;
    unique case (prot_lvl_e'(lvl))
      LVL_NONE:    locked = 1'b0;
      LVL_QUARTER: locked = in_array && ({1'b0, addr} >= lim_q);
      LVL_HALF:    locked = in_array && ({1'b0, addr} >= lim_h);
      LVL_ALL:     locked = in_array;
      default:     locked = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_status_port.sv
module bp_status_port
  import bp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              ext_mode,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [1:0]        bp_level,
  output logic              addr_locked
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);

  logic             rst_n_i;
  logic             bit_stb, bit_val, sel_n, deselect_stb;
  logic             commit_stb;
  logic [1:0]       commit_lvl;
  logic [CNT_W-1:0] bit_cnt;
  logic [1:0]       lvl_q, lvl_n;

  bp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bp_serial_sampler u_smp (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .sck          (sck),
    .cs_n         (cs_n),
    .si           (si),
    .bit_stb      (bit_stb),
    .bit_val      (bit_val),
    .sel_n        (sel_n),
    .deselect_stb (deselect_stb)
  );

  bp_frame_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .bit_stb      (bit_stb),
    .bit_val      (bit_val),
    .sel_n        (sel_n),
    .deselect_stb (deselect_stb),
    .commit_stb   (commit_stb),
    .commit_lvl   (commit_lvl),
    .bit_cnt      (bit_cnt)
  );

  always_comb begin
    lvl_n = lvl_q;
    if (commit_stb) lvl_n = commit_lvl;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) lvl_q <= 2'b00;
    else          lvl_q <= lvl_n;
  end

  bp_range_check #(.ADDR_W(ADDR_W)) u_rng (
    .lvl      (lvl_q),
    .ext_mode (ext_mode),
    .addr     (chk_addr),
    .locked   (addr_locked)
  );

  assign bp_level = lvl_q;
  assign sdo      = 1'b0;
  assign sdo_oe   = 1'b0;
endmodule

// File: rtl/bp_status_port_chk.sv
module bp_status_port_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic              sel_n,
  input logic              deselect_stb,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [1:0]        bp_level,
  input logic              ext_mode,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              addr_locked,
  input logic              sdo_oe
);
  logic [ADDR_W:0] words;
  assign words = ext_mode ? (ADDR_W+1)'(1 << ADDR_W) : (ADDR_W+1)'(1 << (ADDR_W-1));

  a_r1_reset_level: assert property (@(posedge clk) $rose(rst_n_i) |-> bp_level == 2'b00);

  a_r7_hold_selected: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!sel_n && !$past(sel_n)) |-> $stable(bp_level));

  a_r7_change_on_deselect: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bp_level != $past(bp_level)) |-> $past(deselect_stb));

  a_r11_count_clears: assert property (@(posedge clk) disable iff (!rst_n_i)
    sel_n |=> bit_cnt == '0);

  a_r8_none_unlocked: assert property (@(posedge clk) disable iff (!rst_n_i)
    bp_level == 2'b00 |-> !addr_locked);

  a_r8_full_locked: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bp_level == 2'b11 && {1'b0, chk_addr} < words) |-> addr_locked);

  a_r9_outside_free: assert property (@(posedge clk) disable iff (!rst_n_i)
    ({1'b0, chk_addr} >= words) |-> !addr_locked);

  a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n_i) !sdo_oe);
endmodule

bind bp_status_port bp_status_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n_i      (rst_n_i),
  .sel_n        (sel_n),
  .deselect_stb (deselect_stb),
  .bit_cnt      (bit_cnt),
  .bp_level     (bp_level),
  .ext_mode     (ext_mode),
  .chk_addr     (chk_addr),
  .addr_locked  (addr_locked),
  .sdo_oe       (sdo_oe)
);

// File: tb/sim_bp_status_port.sv
module sim_bp_status_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic       ext_mode = 1'b0;
  logic [8:0] chk_addr = '0;
  logic       sdo, sdo_oe, addr_locked;
  logic [1:0] bp_level;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_lvl = 2'b00;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bp_status_port u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .ext_mode(ext_mode), .chk_addr(chk_addr), .sdo(sdo), .sdo_oe(sdo_oe),
    .bp_level(bp_level), .addr_locked(addr_locked)
  );

  function automatic logic prot(input logic [1:0] l, input logic ext, input logic [8:0] a);
    int n;
    n = ext ? 512 : 256;
    if (int'(a) >= n) return 1'b0;
    case (l)
      2'b00:   return 1'b0;
      2'b01:   return int'(a) >= (n * 3) / 4;
      2'b10:   return int'(a) >= n / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [23:0] d);
    @(negedge clk);
    cs_n = 1'b0;
    wclk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = d[i];
      wclk(4);
      sck = 1'b1;
      wclk(4);
      sck = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(8);
    if (nbits == 16 && d[15:8] == 8'h01) exp_lvl = d[3:2];
  endtask

  task automatic addr_sweep(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ext_mode = $urandom_range(0, 1);
      chk_addr = 9'($urandom_range(0, 511));
      #1;
      check(req, addr_locked, prot(bp_level, ext_mode, chk_addr));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wclk(5);
    rst_n = 1'b1;
    wclk(4);
    check("R1 reset level", bp_level, 0);
    check("R10 output enable", sdo_oe, 0);

    // R2 valid frames set each level
    send(16, 24'h0104); check("R2 level 01", bp_level, 1);
    send(16, 24'h0108); check("R2 level 10", bp_level, 2);
    send(16, 24'h010C); check("R2 level 11", bp_level, 3);
    // R8 boundaries in both modes at each level
    for (int l = 0; l < 4; l++) begin
      send(16, 24'h0100 | 24'(l << 2));
      for (int e = 0; e < 2; e++) begin
        int n;
        n = e ? 512 : 256;
        ext_mode = e[0];
        for (int j = 0; j < 6; j++) begin
          int a;
          case (j)
            0: a = n / 2 - 1;  1: a = n / 2;
            2: a = n * 3 / 4 - 1;  3: a = n * 3 / 4;
            4: a = 0;  default: a = n - 1;
          endcase
          @(negedge clk); chk_addr = 9'(a); #1;
          check("R8 range boundary", addr_locked, prot(2'(l), ext_mode, chk_addr));
        end
      end
      ext_mode = 1'b0;
      @(negedge clk); chk_addr = 9'h100; #1;
      check("R9 outside base array", addr_locked, 0);
    end
    // now at level 11
    send(15, 24'h0000); check("R3 short frame", bp_level, 3);
    send(8,  24'h0001); check("R3 code only", bp_level, 3);
    send(17, 24'h00200); check("R4 long frame", bp_level, 3);
    send(16, 24'h0200); check("R5 wrong code", bp_level, 3);
    send(16, 24'h01F3); check("R6 ignored bits", bp_level, 0);
    send(16, 24'h01F7); check("R6 ignored bits", bp_level, 1);
    send(5,  24'h0000);
    send(16, 24'h0108); check("R11 after abort", bp_level, 2);
    // R7 level held mid frame until deselect
    @(negedge clk); cs_n = 1'b0; wclk(4);
    for (int i = 15; i >= 0; i--) begin
      si = 16'h010C >> i; wclk(4); sck = 1'b1; wclk(4); sck = 1'b0;
    end
    wclk(6);
    check("R7 held while selected", bp_level, 2);
    cs_n = 1'b1; wclk(8);
    check("R7 applied on deselect", bp_level, 3);
    exp_lvl = 2'b11;

    // random frames
    for (int t = 0; t < 120; t++) begin
      int nb;
      logic [23:0] d;
      nb = $urandom_range(14, 18);
      d = 24'($urandom);
      if ($urandom_range(0, 1) == 1) d[nb-1 -: 8] = 8'h01;
      send(nb, d);
      check("R2 R3 R4 R5 random frame", bp_level, exp_lvl);
      check("R10 output enable", sdo_oe, 0);
      addr_sweep("R8 R9 random address", 4);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule